// File: doc/BRIEF.md
# Trapezoidal Companion Element

This block stands for one linear energy-storage branch, either an inductor or a capacitor, inside a circuit solver whose conductance matrix never changes. The branch is replaced by a constant companion conductance, which is already part of the matrix, in parallel with a history current source. Only the history source enters the right-hand-side vector. On every solver step the block reads the freshly solved voltages of its two terminal nodes. It updates the branch current and the history source by the trapezoidal rule, and it drives its signed injection onto the two node entries of the source vector. Every such element in a solver runs side by side on the same step strobe.

All quantities are 69-bit two's-complement fixed-point numbers with 41 fractional bits. The step coefficient (Δt/2L for an inductor, 2C/Δt for a capacitor), the element kind, the two node indices and the initial value are applied before the run. A synchronous reset or an init strobe loads the starting state. Every result is clamped to the number range rather than wrapping.

Top module: `tcm_element`

## Requirements
- R1: While `rst_n` is low, each clock edge loads the starting state from the present inputs. For an inductor (`is_cap_i`=0), the branch current becomes `init_val_i` and the history becomes sat(`init_val_i` + G·v). For a capacitor (`is_cap_i`=1), the current becomes 0 and the history becomes sat(`coef_i`·`init_val_i`), where `init_val_i` is read as the initial voltage.
- R2: An edge with `init_i` high loads the same starting state as R1. `init_i` wins over `step_i` when both are high.
- R3: Numbers are 69-bit two's complement with 41 fraction bits. v = sat(x[p] − x[n]). G·v = sat(floor(`coef_i`·v / 2^41)). On an inductor step, the new current is sat(history + G·v) and the new history is sat(new current + G·v).
- R4: On a capacitor step, the new current is sat(G·v − history) and the new history is sat(G·v + new current).
- R5: Let the injection be +history for a capacitor and sat(−history) for an inductor. Source-vector entry k−1 of `b_o` (bits [(k−1)·69 +: 69]) equals sat((p==k ? injection : 0) − (n==k ? injection : 0)). All other entries are 0.
- R6: Node index 0 is ground. It reads as 0 V and owns no entry. An element with both terminals on the same node drives no entry.
- R7: Every sum, difference and product saturates to the range [−2^68, 2^68−1] and never wraps.
- R8: With neither `init_i` nor `step_i` high, the current and history hold, whatever happens to the voltages, the coefficient or the initial value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the starting state |
| init_i | input | 1 | Strobe that loads the starting state |
| step_i | input | 1 | Solver step strobe |
| is_cap_i | input | 1 | 1 = capacitor, 0 = inductor |
| coef_i | input | 69 | Step coefficient, fixed point |
| init_val_i | input | 69 | Initial current (inductor) or voltage (capacitor) |
| node_p_i | input | $clog2(NODES+1) | Positive-terminal node index, 0 = ground |
| node_n_i | input | $clog2(NODES+1) | Negative-terminal node index, 0 = ground |
| x_prev_i | input | NODES·69 | Previous solution, node k at bits [(k−1)·69 +: 69] |
| b_o | output | NODES·69 | Contribution to the source vector, same layout |
| i_branch_o | output | 69 | Branch current after the latest load or step |

## Verification
The assertions assume that the element kind and the node indices stay fixed between a load and the steps that follow it. They also assume that `init_i` and `step_i` are sampled cleanly once per edge. The bench changes kind and nodes only right before an init strobe or while the strobes are low, except in the node-index sweep, which checks only the combinational source-vector mapping. Small coefficients and voltages keep the stepping sweeps inside the number range. Saturation is then driven on purpose with full-scale node voltages and a unity coefficient.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int DATA_W = 69;
  localparam int FRAC_W = 41;
  localparam int WIDE_W = 2 * DATA_W;

  typedef logic signed [DATA_W-1:0] fx_t;
  typedef logic signed [WIDE_W-1:0] wide_t;

  localparam fx_t FX_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam fx_t FX_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  // sign-extend a fixed-point word into the wide working type
  function automatic wide_t widen(input fx_t a);
    return $signed({{DATA_W{a[DATA_W-1]}}, a});
  endfunction

  // clamp a wide intermediate back into the fixed-point range
  function automatic fx_t clamp(input wide_t a);
    if (a > widen(FX_MAX)) return FX_MAX;
    if (a < widen(FX_MIN)) return FX_MIN;
    return a[DATA_W-1:0];
  endfunction

  function automatic fx_t fx_add(input fx_t a, input fx_t b);
    return clamp(widen(a) + widen(b));
  endfunction

  function automatic fx_t fx_sub(input fx_t a, input fx_t b);
    return clamp(widen(a) - widen(b));
  endfunction

  // product rescaled by the fraction width, rounding toward minus infinity
  function automatic fx_t fx_mul(input fx_t a, input fx_t b);
    wide_t p;
    p = widen(a) * widen(b);
    return clamp(p >>> FRAC_W);
  endfunction
endpackage

// File: rtl/tcm_volt_pick.sv
module tcm_volt_pick
  import tcm_pkg::*;
#(
  parameter int NODES = 4,
  parameter int IDX_W = $clog2(NODES + 1)
) (
  input  logic [NODES*DATA_W-1:0] x_prev_i,
  input  logic [IDX_W-1:0]        node_p_i,
  input  logic [IDX_W-1:0]        node_n_i,
  output fx_t                     v_branch_o
);
  localparam int SLOTS = 1 << IDX_W;

  fx_t nv [SLOTS];

  // slot 0 is ground; slots beyond the node count also read as ground
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s >= 1 && s <= NODES) begin : g_node
      assign nv[s] = x_prev_i[(s-1)*DATA_W +: DATA_W];
    end else begin : g_gnd
      assign nv[s] = '0;
    end
  end

  assign v_branch_o = fx_sub(nv[node_p_i], nv[node_n_i]);
endmodule

// File: rtl/tcm_hist_core.sv
module tcm_hist_core
  import tcm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic step_i,
  input  logic is_cap_i,
  input  fx_t  coef_i,
  input  fx_t  init_val_i,
  input  fx_t  v_i,
  output fx_t  hist_o,
  output fx_t  cur_o
);
  fx_t hist_q, cur_q;
  fx_t gv;
  fx_t cur_ld, hist_ld;
  fx_t cur_nx, hist_nx;
  logic load_ev, step_ev;

  assign load_ev = !rst_n || init_i;
  assign step_ev = rst_n && !init_i && step_i;
  assign gv      = fx_mul(coef_i, v_i);

  always_comb begin
    if (is_cap_i) begin
      cur_ld  = '0;
      hist_ld = fx_mul(coef_i, init_val_i);
      cur_nx  = fx_sub(gv, hist_q);
      hist_nx = fx_add(gv, cur_nx);
    end else begin
      cur_ld  = init_val_i;
      hist_ld = fx_add(init_val_i, gv);
      cur_nx  = fx_add(hist_q, gv);
      hist_nx = fx_add(cur_nx, gv);
    end
  end

  always_ff @(posedge clk) begin
    if (load_ev) begin
      cur_q  <= cur_ld;
      hist_q <= hist_ld;
    end else if (step_ev) begin
      cur_q  <= cur_nx;
      hist_q <= hist_nx;
    end
  end

  assign hist_o = hist_q;
  assign cur_o  = cur_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !step_i) |=> ($stable(hist_q) && $stable(cur_q)));

  p_init_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && !is_cap_i) |=> (cur_q == $past(init_val_i)));

  p_cap_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && is_cap_i) |=> (cur_q == '0));

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !is_cap_i && !gv[DATA_W-1]) |=> ($signed(cur_q) >= $signed($past(hist_q))));

  p_no_wrap_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !is_cap_i && gv[DATA_W-1]) |=> ($signed(cur_q) <= $signed($past(hist_q))));
endmodule

// File: rtl/tcm_b_scatter.sv
module tcm_b_scatter
  import tcm_pkg::*;
#(
  parameter int NODES = 4,
  parameter int IDX_W = $clog2(NODES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    is_cap_i,
  input  fx_t                     hist_i,
  input  logic [IDX_W-1:0]        node_p_i,
  input  logic [IDX_W-1:0]        node_n_i,
  output logic [NODES*DATA_W-1:0] b_o
);
  fx_t inj;
  logic [NODES-1:0] nz;

  assign inj = is_cap_i ? hist_i : fx_sub('0, hist_i);

  for (genvar k = 1; k <= NODES; k++) begin : g_entry
    fx_t plus, minus;
    assign plus  = (node_p_i == IDX_W'(k)) ? inj : '0;
    assign minus = (node_n_i == IDX_W'(k)) ? inj : '0;
    assign b_o[(k-1)*DATA_W +: DATA_W] = fx_sub(plus, minus);
    assign nz[k-1] = |b_o[(k-1)*DATA_W +: DATA_W];
  end

  p_two_entries_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(nz) <= 2);

  p_ground_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (node_p_i == node_n_i) |-> (nz == '0));
endmodule

// File: rtl/tcm_element.sv
module tcm_element
  import tcm_pkg::*;
#(
  parameter int NODES = 4,
  localparam int IDX_W = $clog2(NODES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init_i,
  input  logic                    step_i,
  input  logic                    is_cap_i,
  input  logic [DATA_W-1:0]       coef_i,
  input  logic [DATA_W-1:0]       init_val_i,
  input  logic [IDX_W-1:0]        node_p_i,
  input  logic [IDX_W-1:0]        node_n_i,
  input  logic [NODES*DATA_W-1:0] x_prev_i,
  output logic [NODES*DATA_W-1:0] b_o,
  output logic [DATA_W-1:0]       i_branch_o
);
  fx_t v_branch, hist, cur;

  tcm_volt_pick #(.NODES(NODES), .IDX_W(IDX_W)) u_pick (
    .x_prev_i   (x_prev_i),
    .node_p_i   (node_p_i),
    .node_n_i   (node_n_i),
    .v_branch_o (v_branch)
  );

  tcm_hist_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .step_i     (step_i),
    .is_cap_i   (is_cap_i),
    .coef_i     (fx_t'(coef_i)),
    .init_val_i (fx_t'(init_val_i)),
    .v_i        (v_branch),
    .hist_o     (hist),
    .cur_o      (cur)
  );

  tcm_b_scatter #(.NODES(NODES), .IDX_W(IDX_W)) u_scatter (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_cap_i (is_cap_i),
    .hist_i   (hist),
    .node_p_i (node_p_i),
    .node_n_i (node_n_i),
    .b_o      (b_o)
  );

  assign i_branch_o = cur;
endmodule

// File: tb/test_tcm_element.sv
module test_tcm_element;
  localparam int CLK_PERIOD = 10;
  localparam int NN = 3;
  localparam int WW = 69;
  localparam int IW = 2;

  typedef logic signed [WW-1:0] v_t;
  typedef logic signed [139:0] big_t;

  localparam v_t VMAX = {1'b0, {(WW-1){1'b1}}};
  localparam v_t VMIN = {1'b1, {(WW-1){1'b0}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_i = 1'b0, step_i = 1'b0, is_cap_i = 1'b0;
  logic [WW-1:0] coef_i = '0, init_val_i = '0;
  logic [IW-1:0] node_p_i = '0, node_n_i = '0;
  logic [NN*WW-1:0] x_prev_i = '0;
  logic [NN*WW-1:0] b_o;
  logic [WW-1:0] i_branch_o;

  int checks = 0, failures = 0;
  bit done = 0;
  v_t m_hist, m_cur;

  tcm_element #(.NODES(NN)) i_tcm_element (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .step_i(step_i),
    .is_cap_i(is_cap_i), .coef_i(coef_i), .init_val_i(init_val_i),
    .node_p_i(node_p_i), .node_n_i(node_n_i), .x_prev_i(x_prev_i),
    .b_o(b_o), .i_branch_o(i_branch_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference arithmetic, 140-bit working width
  function automatic big_t ext(input v_t a);
    return $signed({{71{a[WW-1]}}, a});
  endfunction
  function automatic v_t fit(input big_t a);
    big_t hi, lo;
    hi = (big_t'(1) <<< 68) - 1;
    lo = -(big_t'(1) <<< 68);
    if (a >= hi) return VMAX;
    if (a <= lo) return VMIN;
    return v_t'(a);
  endfunction
  function automatic v_t m_add(input v_t a, input v_t b); return fit(ext(a) + ext(b)); endfunction
  function automatic v_t m_sub(input v_t a, input v_t b); return fit(ext(a) - ext(b)); endfunction
  function automatic v_t m_mul(input v_t a, input v_t b);
    big_t p;
    p = ext(a) * ext(b);
    return fit(p >>> 41);
  endfunction
  // n sixteenths in fixed point
  function automatic v_t q(input int n);
    v_t r;
    r = {{37{n[31]}}, n};
    return r <<< 37;
  endfunction
  function automatic v_t xv(input int k);
    if (k < 1 || k > NN) return '0;
    return x_prev_i[(k-1)*WW +: WW];
  endfunction
  function automatic v_t exp_b(input int k);
    v_t inj, pl, mi;
    inj = is_cap_i ? m_hist : m_sub('0, m_hist);
    pl = (int'(node_p_i) == k) ? inj : '0;
    mi = (int'(node_n_i) == k) ? inj : '0;
    return m_sub(pl, mi);
  endfunction

  task automatic check(input string tag, input v_t act, input v_t exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " current"}, v_t'(i_branch_o), m_cur);
    for (int k = 1; k <= NN; k++)
      check({tag, " b entry"}, v_t'(b_o[(k-1)*WW +: WW]), exp_b(k));
  endtask

  task automatic set_x(input int k, input v_t val);
    x_prev_i[(k-1)*WW +: WW] = val;
  endtask

  task automatic model_load();
    v_t gv;
    gv = m_mul(v_t'(coef_i), m_sub(xv(int'(node_p_i)), xv(int'(node_n_i))));
    if (is_cap_i) begin m_cur = '0; m_hist = m_mul(v_t'(coef_i), v_t'(init_val_i)); end
    else begin m_cur = v_t'(init_val_i); m_hist = m_add(v_t'(init_val_i), gv); end
  endtask

  task automatic model_step();
    v_t gv;
    gv = m_mul(v_t'(coef_i), m_sub(xv(int'(node_p_i)), xv(int'(node_n_i))));
    if (is_cap_i) begin m_cur = m_sub(gv, m_hist); m_hist = m_add(gv, m_cur); end
    else begin m_cur = m_add(m_hist, gv); m_hist = m_add(m_cur, gv); end
  endtask

  // inputs are set at a falling edge; results sampled at the next falling edge
  task automatic cycle(input logic st, input logic in);
    step_i = st; init_i = in;
    if (in) model_load(); else if (st) model_step();
    @(posedge clk);
    @(negedge clk);
    step_i = 0; init_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset loads inductor state
    is_cap_i = 0; coef_i = q(4); init_val_i = q(48);
    node_p_i = 1; node_n_i = 2;
    set_x(1, q(32)); set_x(2, q(8)); set_x(3, q(-5));
    model_load();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset current", v_t'(i_branch_o), q(48));
    check_all("R1 reset");

    // R8: no strobe, inputs wander, state holds
    for (int i = 0; i < 4; i++) begin
      set_x(1, q(i * 11 - 20)); coef_i = q(i + 1); init_val_i = q(-i);
      cycle(0, 0);
      check_all("R8 hold");
    end

    // R3: inductor stepping over varied voltages, coefficients and terminals
    for (int s = 0; s < 30; s++) begin
      set_x(1, q((s * 7) % 13 - 6)); set_x(2, q((s * 5) % 9 - 4)); set_x(3, q((s * 3) % 11 - 5));
      coef_i = q(1 + s % 4);
      if (s == 10) begin node_p_i = 2; node_n_i = 3; end
      if (s == 20) begin node_p_i = 0; node_n_i = 3; end
      cycle(1, 0);
      check_all("R3 inductor step");
    end

    // R2: init on a capacitor, then init beats step
    is_cap_i = 1; coef_i = q(24); init_val_i = q(-20); node_p_i = 1; node_n_i = 2;
    cycle(0, 1);
    check("R2 cap init current", v_t'(i_branch_o), '0);
    check_all("R2 init");
    is_cap_i = 0; init_val_i = q(9);
    cycle(1, 1);
    check("R2 init priority", v_t'(i_branch_o), q(9));
    check_all("R2 init priority");

    // R4: capacitor stepping
    is_cap_i = 1; coef_i = q(8); init_val_i = q(16);
    cycle(0, 1);
    for (int s = 0; s < 30; s++) begin
      set_x(1, q((s * 9) % 17 - 8)); set_x(2, q((s * 4) % 7 - 3)); set_x(3, q(s % 5));
      coef_i = q(4 + s % 3 * 4);
      if (s == 15) begin node_p_i = 3; node_n_i = 0; end
      cycle(1, 0);
      check_all("R4 capacitor step");
    end

    // R5/R6: every terminal pairing on both kinds
    for (int c = 0; c < 2; c++) begin
      is_cap_i = c[0];
      for (int p = 0; p <= NN; p++)
        for (int n = 0; n <= NN; n++) begin
          node_p_i = IW'(p); node_n_i = IW'(n);
          #2;
          if (p == n) check("R6 same node silent", v_t'(b_o[0 +: WW]) | v_t'(b_o[WW +: WW]) | v_t'(b_o[2*WW +: WW]), '0);
          check_all("R5 R6 scatter");
        end
      @(negedge clk);
    end

    // R6: ground terminal reads 0 V
    is_cap_i = 0; coef_i = q(16); init_val_i = '0; node_p_i = 0; node_n_i = 1;
    set_x(1, q(5));
    cycle(0, 1);
    check("R6 ground voltage", v_t'(i_branch_o), '0);
    cycle(1, 0);
    check("R6 ground voltage step", v_t'(i_branch_o), q(-10));
    check_all("R6 ground");

    // R7: saturation in both directions
    node_p_i = 1; node_n_i = 2; coef_i = q(16); init_val_i = q(100);
    set_x(1, VMAX); set_x(2, VMIN);
    cycle(0, 1);
    check_all("R7 sat load");
    cycle(1, 0);
    check("R7 sat positive", v_t'(i_branch_o), VMAX);
    check_all("R7 sat high");
    set_x(1, VMIN); set_x(2, VMAX);
    cycle(1, 0);
    check("R7 sat crossing", v_t'(i_branch_o), v_t'(-1));
    cycle(1, 0);
    check("R7 sat negative", v_t'(i_branch_o), VMIN);
    check_all("R7 sat low");
    is_cap_i = 1;
    cycle(0, 1);
    cycle(1, 0);
    check_all("R7 cap sat");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule